// File: doc/BRIEF.md
# Three-Wire Addressed Control Port

This block is a write-only serial control slave. A host drives three lines: a data line, a mode line and a serial clock. The block resamples all three into the faster system clock domain and shifts in one bit per rising edge of the serial clock, least significant bit first. The mode line tells the two kinds of byte apart. While it is low, bytes are address bytes. While it is high, bytes are data bytes.

An address byte carries a six-bit device identity in its upper bits and a two-bit transfer type in its lower bits. A matching identity selects the port and latches the transfer type. Both stay in force for any number of data bytes until the next address byte arrives. Each completed data byte uses its upper two bits to pick one of four registers and its lower six bits as the value. The register comes from the data bank or the status bank, depending on the latched transfer type. A byte takes effect only once all eight bits are in. Toggling the mode line throws away any partial byte.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset all eight six-bit registers read zero and the port is deselected, so data bytes sent before any address byte change nothing.
- R2: A byte received with the mode line low is an address byte. Its bits 7..2, with bit 7 most significant, are compared with the identity 6'b000101, and a match selects the port.
- R3: An address byte with any other identity deselects the port, and every data byte after it leaves all registers unchanged.
- R4: Address bits 1..0 give the transfer type. 2'b00 routes data bytes to the data bank and 2'b10 routes them to the status bank.
- R5: With transfer type 2'b01 or 2'b11, data bytes leave all registers unchanged.
- R6: The selection and transfer type persist across any number of consecutive data bytes until a new address byte is received.
- R7: In a data byte, bits 7..6 index a register (0..3) of the chosen bank and bits 5..0 become its value. The other seven registers keep their values.
- R8: Bits are taken least significant first. The first bit clocked in is bit 0 and the eighth is bit 7.
- R9: Any change of the mode line discards a partially received byte. The next full byte is assembled from bits that arrive after the change.
- R10: No register changes before the eighth bit of a data byte has been received.
- R11: Each bit is sampled at the rising edge of the serial clock. A change on the data line while the serial clock stays high has no effect on that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_dat_i | input | 1 | Serial data line |
| ctl_mode_i | input | 1 | Mode line: low = address byte, high = data byte |
| ctl_clk_i | input | 1 | Serial clock; data sampled on its rising edge |
| data_bank_o | output | 24 | Data bank, register i in bits [6*i+5:6*i] |
| stat_bank_o | output | 24 | Status bank, register i in bits [6*i+5:6*i] |

## Verification
The hardest situation to reach from the ports is a byte boundary that does not line up with the mode line. Examples are a byte cut short by a mode change, a byte that has received seven bits but not the eighth, and a data line that moves while the serial clock is high. The bench drives bit by bit through a task that can stop after any number of bits, switch the mode line in the middle of a byte, or flip the data line during the high phase. It checks the banks at each of these points against its own model. A full sweep of all 64 identities and all four transfer types exercises selection, deselection and persistence.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;
  localparam int NREG   = 1 << IDX_W;
  localparam int VAL_W  = BYTE_W - IDX_W;
  localparam int ID_W   = BYTE_W - 2;

  typedef enum logic [1:0] {
    XF_DATA = 2'b00,
    XF_RSV1 = 2'b01,
    XF_STAT = 2'b10,
    XF_RSV3 = 2'b11
  } xfer_t;

  // identity compare on bits 7..2 of an address byte
  function automatic logic id_match(input logic [BYTE_W-1:0] b,
                                    input logic [ID_W-1:0]   dev);
    return b[BYTE_W-1 -: ID_W] == dev;
  endfunction

  function automatic xfer_t xfer_of(input logic [BYTE_W-1:0] b);
    return xfer_t'(b[1:0]);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: IDX_W];
  endfunction

  function automatic logic [VAL_W-1:0] value_of(input logic [BYTE_W-1:0] b);
    return b[VAL_W-1:0];
  endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_dat,
  input  logic              s_mode,
  input  logic              s_clk,
  output logic              byte_vld,
  output logic              byte_is_addr,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              clk_q;
  logic              mode_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;
  logic              rise_evt;
  logic              mode_chg;
  logic [CNT_W-1:0]  cnt_base;
  logic [BYTE_W-1:0] sr_next;
  logic              last_bit;

  assign rise_evt = s_clk & ~clk_q;
  assign mode_chg = s_mode ^ mode_q;
  assign cnt_base = mode_chg ? '0 : cnt;
  assign sr_next  = {s_dat, sr[BYTE_W-1:1]};
  assign last_bit = rise_evt && (cnt_base == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q        <= 1'b0;
      mode_q       <= 1'b0;
      cnt          <= '0;
      sr           <= '0;
      byte_vld     <= 1'b0;
      byte_is_addr <= 1'b0;
      byte_q       <= '0;
    end else begin
      clk_q    <= s_clk;
      mode_q   <= s_mode;
      byte_vld <= 1'b0;
      if (rise_evt) begin
        sr  <= sr_next;
        cnt <= cnt_base + CNT_W'(1);
      end else if (mode_chg) begin
        cnt <= '0;
      end
      if (last_bit) begin
        byte_vld     <= 1'b1;
        byte_q       <= sr_next;
        byte_is_addr <= ~s_mode;
      end
    end
  end

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !rise_evt) |=> (cnt == '0)); // R9

  AST_BYTE_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(rise_evt) && $past(cnt_base) == CNT_W'(BYTE_W - 1))); // R10
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_is_addr,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              wr_data,
  output logic              wr_stat,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [VAL_W-1:0]  wr_val
);
  logic  sel;
  xfer_t xfer;
  logic  data_evt;
  logic  addr_evt;

  assign addr_evt = byte_vld &  byte_is_addr;
  assign data_evt = byte_vld & ~byte_is_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      xfer <= XF_DATA;
    end else if (addr_evt) begin
      sel  <= id_match(byte_q, DEV_ID);
      xfer <= xfer_of(byte_q);
    end
  end

  assign wr_data = data_evt && sel && (xfer == XF_DATA);
  assign wr_stat = data_evt && sel && (xfer == XF_STAT);
  assign wr_idx  = slot_of(byte_q);
  assign wr_val  = value_of(byte_q);

  AST_ADDR_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt |-> !(wr_data || wr_stat)); // R2

  AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !(wr_data || wr_stat)); // R3

  AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == XF_RSV1 || xfer == XF_RSV3) |-> !(wr_data || wr_stat)); // R5

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data, wr_stat})); // R4
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [VAL_W-1:0]      wr_val,
  output logic [NREG*VAL_W-1:0] bank
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i*VAL_W +: VAL_W] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        bank[i*VAL_W +: VAL_W] <= wr_val;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank)); // R10

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank[$past(wr_idx)*VAL_W +: VAL_W] == $past(wr_val))); // R7
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import sctl_pkg::*;
#(
  parameter logic [5:0] DEV_ID      = 6'b000101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_dat_i,
  input  logic                  ctl_mode_i,
  input  logic                  ctl_clk_i,
  output logic [NREG*VAL_W-1:0] data_bank_o,
  output logic [NREG*VAL_W-1:0] stat_bank_o
);
  logic [2:0]        raw_in;
  logic [2:0]        syn_in;
  logic              byte_vld;
  logic              byte_is_addr;
  logic [BYTE_W-1:0] byte_q;
  logic              wr_data;
  logic              wr_stat;
  logic [IDX_W-1:0]  wr_idx;
  logic [VAL_W-1:0]  wr_val;

  assign raw_in = {ctl_clk_i, ctl_mode_i, ctl_dat_i};

  sctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  sctl_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .s_dat(syn_in[0]), .s_mode(syn_in[1]), .s_clk(syn_in[2]),
    .byte_vld(byte_vld), .byte_is_addr(byte_is_addr), .byte_q(byte_q)
  );

  sctl_decode #(.DEV_ID(DEV_ID)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(byte_vld), .byte_is_addr(byte_is_addr), .byte_q(byte_q),
    .wr_data(wr_data), .wr_stat(wr_stat), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  sctl_regbank u_data_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_data),
    .wr_idx(wr_idx), .wr_val(wr_val), .bank(data_bank_o)
  );

  sctl_regbank u_stat_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stat),
    .wr_idx(wr_idx), .wr_val(wr_val), .bank(stat_bank_o)
  );
endmodule

// File: tb/serial_ctl_port_tb.sv
`timescale 1ns/1ps
module serial_ctl_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_dat = 1'b0;
  logic ctl_mode = 1'b0;
  logic ctl_clk = 1'b0;
  logic [23:0] data_bank;
  logic [23:0] stat_bank;

  int tests = 0;
  int fails = 0;
  logic [5:0] exp_data [4];
  logic [5:0] exp_stat [4];
  logic       m_sel = 1'b0;
  logic [1:0] m_type = 2'b00;

  always #2.5 clk = ~clk;

  serial_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_dat_i(ctl_dat), .ctl_mode_i(ctl_mode), .ctl_clk_i(ctl_clk),
    .data_bank_o(data_bank), .stat_bank_o(stat_bank)
  );

  function automatic logic [23:0] pack(input logic [5:0] r [4]);
    logic [23:0] f;
    for (int i = 0; i < 4; i++) f[i*6 +: 6] = r[i];
    return f;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [23:0] ed;
    logic [23:0] es;
    ed = pack(exp_data);
    es = pack(exp_stat);
    wait_clk(10);
    tests++;
    if (data_bank !== ed || stat_bank !== es) begin
      fails++;
      $display("FAIL %s: data act %h exp %h, stat act %h exp %h",
               tag, data_bank, ed, stat_bank, es);
    end
  endtask

  // model: apply a complete byte
  task automatic model_byte(input logic mode, input logic [7:0] b);
    if (!mode) begin
      m_sel  = (b[7:2] == 6'b000101);
      m_type = b[1:0];
    end else if (m_sel) begin
      if (m_type == 2'b00) exp_data[b[7:6]] = b[5:0];
      else if (m_type == 2'b10) exp_stat[b[7:6]] = b[5:0];
    end
  endtask

  // send the low n bits, bit 0 first; flip toggles data while clock is high
  task automatic send_bits(input logic mode, input logic [7:0] b,
                           input int n, input logic flip);
    if (ctl_mode !== mode) begin
      ctl_mode = mode;
      wait_clk(8);
    end
    for (int i = 0; i < n; i++) begin
      ctl_dat = b[i];
      wait_clk(4);
      ctl_clk = 1'b1;
      wait_clk(4);
      if (flip) ctl_dat = ~b[i];
      wait_clk(4);
      ctl_clk = 1'b0;
      wait_clk(4);
    end
    if (n == 8) model_byte(mode, b);
  endtask

  task automatic send_byte(input logic mode, input logic [7:0] b);
    send_bits(mode, b, 8, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin exp_data[i] = '0; exp_stat[i] = '0; end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check_all("R1 reset");
    send_byte(1'b1, 8'hC5);
    check_all("R1 deselected at reset");

    // identity sweep
    for (int a = 0; a < 64; a++) begin
      logic [5:0] id6 = 6'(a);
      send_byte(1'b0, {id6, 2'b00});
      send_byte(1'b1, {id6[1:0], id6 ^ 6'h2A});
      if (a == 5) check_all("R2 match");
      else        check_all("R3 mismatch");
    end

    // transfer type sweep, four registers each, consecutive data bytes
    for (int t = 0; t < 4; t++) begin
      send_byte(1'b0, {6'b000101, 2'(t)});
      for (int k = 0; k < 4; k++) begin
        send_byte(1'b1, {2'(k), 6'(t*16 + k*5 + 1)});
        if (t == 0 || t == 2) check_all("R4 R7 bank write");
        else                  check_all("R5 reserved type");
      end
    end

    // persistence over a long run of data bytes
    send_byte(1'b0, {6'b000101, 2'b00});
    for (int k = 0; k < 20; k++) begin
      send_byte(1'b1, {2'(k % 4), 6'(k * 3 + 7)});
      check_all("R6 persistence");
    end

    // bit order
    send_byte(1'b0, {6'b000101, 2'b10});
    send_byte(1'b1, 8'b01_000011);
    check_all("R8 lsb first");
    send_byte(1'b1, 8'b10_110000);
    check_all("R8 lsb first");

    // partial byte: seven bits then the eighth
    send_bits(1'b1, 8'b11_101010, 7, 1'b0);
    check_all("R10 seven bits");
    send_bits(1'b1, 8'b0, 1, 1'b0);
    ctl_dat = 1'b1;
    model_byte(1'b1, 8'b01_101010);
    check_all("R10 eighth bit");

    // mode change discards partial byte
    send_bits(1'b1, 8'b00_111111, 5, 1'b0);
    send_byte(1'b0, {6'b000101, 2'b00});
    send_byte(1'b1, 8'b00_010101);
    check_all("R9 data partial dropped");
    send_bits(1'b0, 8'hFF, 3, 1'b0);
    send_byte(1'b1, 8'b11_001100);
    check_all("R9 address partial dropped");

    // data moving during clock high
    send_bits(1'b1, 8'b10_011001, 8, 1'b1);
    check_all("R11 rising-edge sample");
    send_bits(1'b1, 8'b01_100110, 8, 1'b1);
    check_all("R11 rising-edge sample");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule